// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

The block holds three down-counting interval timers that all run from one shared oscillator tick. Each timer sits behind its own fixed prescaler: /10 for timer 0 and /1000 for timers 1 and 2. Timers 0 and 1 are 16 bits wide and timer 2 is 24 bits wide. Software reaches every count through a narrow window. A select register picks the timer and, for timer 2, the half. A 16-bit data port then loads a divisor or reads the live count.

Each timer has four counting behaviours:

- terminal-count event only;
- rate generator;
- strobe started by software;
- strobe started by hardware.

Timer 0 paces conversions and timer 1 paces scan starts for a downstream acquisition sequencer. Timer 2 can take its clock from the prescaled oscillator, from timer 1's output, or from end-of-conversion or end-of-scan events. It can act as a timer, an event counter or a watchdog. It raises a sticky terminal-count flag, which an interrupt enable gates onto `irq`. A read of the select register address clears the flag.

The oscillator arrives as a one-cycle enable `osc_en`. The bus is a plain single-cycle read and write port. `rdata` is combinational from `addr`, and `rd_en` matters only for the read side effect.

Top module: `tri_timer_unit`

## Requirements
- R1: After reset, every output is 0, the data port reads 0 for every timer, and the mode, control, sequencer-mode and status registers read 0.
- R2: When mode field 1 (rate generator) is selected and the gate is set, timer 0 pulses `pace_tick[0]` for one cycle every 10·N clock cycles (with `osc_en` held high). N is the loaded divisor.
- R3: Timer 1 in rate-generator mode pulses `pace_tick[1]` every 1000·N cycles.
- R4: A loaded divisor below 2 is replaced by 2. The data port then reads back 2.
- R5: A timer whose gate bit is clear holds its count and emits no pulse. Control register (address 3) bit 12+t is the gate of timer t.
- R6: Mode 2 (software strobe) starts one timed period when a divisor is written. At expiry it emits exactly one `pace_tick` pulse and then rests at count 0.
- R7: Mode 3 (hardware strobe) loads without counting. A one-cycle `hw_trig[t]` pulse starts one timed period that ends in a single pulse.
- R8: Address 0 is the select register. Its bits 1:0 give code t, which targets the low 16 bits of timer t, and code 3 targets bits 23:16 of timer 2. Address 1 is the data port. Writing either half of timer 2 loads the combined 24-bit value.
- R9: A timer 2 terminal count sets status (address 5) bit 12. `irq` equals that flag AND sequencer-mode (address 4) bit 2. A read of address 0 clears the flag.
- R10: Sequencer-mode bits 7:6 choose the clock of timer 2: 0 for the oscillator /1000, 1 for `pace_tick[1]`, 2 for `eoc_evt`, 3 for `eos_evt`.
- R11: Sequencer-mode bits 5:4 choose the function of timer 2. Value 1 (counter) takes the oscillator source unprescaled. Value 2 (watchdog) sets `wdog_bark` at terminal count, and `wdog_bark` stays set until timer 2 is loaded again.
- R12: `dout` always shows bits 7:4 of the last value written to the select register.
- R13: Mode 0 (terminal-count event) counts down once, pulses `term_tick[t]`, rests at 0, and emits no `pace_tick` pulse. The mode register (address 2) holds the 2-bit field of timer t at bits 2t+1:2t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | Base oscillator tick, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effects only) |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| eoc_evt | input | 1 | End-of-conversion event pulse |
| eos_evt | input | 1 | End-of-scan event pulse |
| hw_trig | input | 3 | Hardware strobe triggers, one per timer |
| pace_tick | output | 3 | Output pulse per timer (0: conversion, 1: scan start) |
| term_tick | output | 3 | Terminal-count pulse per timer |
| irq | output | 1 | Timer 2 interrupt request |
| wdog_bark | output | 1 | Watchdog expiry, sticky until timer 2 is reloaded |
| dout | output | 4 | Digital output levels |

## Verification
The hardest state to reach from the ports is timer 2 clocked by timer 1's output. It takes two cascaded prescaled periods before any terminal count can appear, and the prescaler phase is unknown at load time. The bench starts both timers back to back. It then checks that the flag is still clear at a point too early for two timer 1 pulses, and that it is set once the worst-case second pulse has passed. The short event sources are driven pulse by pulse, so the flag can be checked one event before and one event after expiry. A pulse on the source that is not selected is checked to have no effect.

// File: rtl/ttu_pkg.sv
package ttu_pkg;

    localparam int NUM_TMR  = 3;
    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 24;

    typedef enum logic [1:0] {
        MD_TERM  = 2'd0,
        MD_RATE  = 2'd1,
        MD_SWSTB = 2'd2,
        MD_HWSTB = 2'd3
    } tmode_e;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_T1   = 2'd1,
        SRC_EOC  = 2'd2,
        SRC_EOS  = 2'd3
    } t2src_e;

    typedef enum logic [1:0] {
        FN_TIMER = 2'd0,
        FN_COUNT = 2'd1,
        FN_WDOG  = 2'd2,
        FN_RSVD  = 2'd3
    } t2fn_e;

    localparam logic [2:0] A_SEL    = 3'd0;
    localparam logic [2:0] A_DATA   = 3'd1;
    localparam logic [2:0] A_TMODE  = 3'd2;
    localparam logic [2:0] A_CTRL   = 3'd3;
    localparam logic [2:0] A_SEQ    = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;

endpackage

// File: rtl/ttu_prescaler.sv
module ttu_prescaler #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        tick_o = 1'b0;
        if (en_i) begin
            if (cnt_q == LAST) begin
                cnt_d  = '0;
                tick_o = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ttu_counter.sv
module ttu_counter
    import ttu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         gate_i,
    input  tmode_e       mode_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         trig_i,
    output logic [W-1:0] cnt_o,
    output logic         pulse_o,
    output logic         term_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rel;
        logic         armed;
        logic         pulse;
        logic         term;
    } cstate_t;

    cstate_t s_d, s_q;
    logic [W-1:0] clamped;

    always_comb begin
        clamped = (load_val_i < W'(2)) ? W'(2) : load_val_i;
        s_d       = s_q;
        s_d.pulse = 1'b0;
        s_d.term  = 1'b0;
        if (load_i) begin
            s_d.rel   = clamped;
            s_d.cnt   = clamped;
            s_d.armed = (mode_i != MD_HWSTB);
        end else if (trig_i && mode_i == MD_HWSTB) begin
            s_d.cnt   = s_q.rel;
            s_d.armed = 1'b1;
        end else if (tick_i && gate_i && s_q.armed) begin
            if (s_q.cnt == W'(1)) begin
                s_d.term = 1'b1;
                if (mode_i == MD_RATE) begin
                    s_d.cnt   = s_q.rel;
                    s_d.pulse = 1'b1;
                end else begin
                    s_d.cnt   = '0;
                    s_d.armed = 1'b0;
                    s_d.pulse = (mode_i != MD_TERM);
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign pulse_o = s_q.pulse;
    assign term_o  = s_q.term;

    // R4
    cnt_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (s_q.cnt >= W'(2)));

    // R5
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !load_i && !trig_i) |=> $stable(s_q.cnt));

    // R6
    strobe_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pulse && $past(mode_i) != MD_RATE) |-> (s_q.cnt == '0));

    // R2
    rate_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pulse && $past(mode_i) == MD_RATE) |-> (s_q.cnt == s_q.rel));

endmodule

// File: rtl/tri_timer_unit.sv
module tri_timer_unit
    import ttu_pkg::*;
#(
    parameter int PRESC0 = 10,
    parameter int PRESC1 = 1000,
    parameter int PRESC2 = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_en,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    input  logic        eoc_evt,
    input  logic        eos_evt,
    input  logic [2:0]  hw_trig,
    output logic [2:0]  pace_tick,
    output logic [2:0]  term_tick,
    output logic        irq,
    output logic        wdog_bark,
    output logic [3:0]  dout
);
    localparam int HI_W = WIDE_W - NARROW_W;

    typedef struct packed {
        logic [7:0]        sel;
        logic [5:0]        tmode;
        logic [2:0]        gate;
        logic [7:0]        seq;
        logic [WIDE_W-1:0] stage2;
        logic              flag;
        logic              bark;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_TMR-1:0] presc_tick, tmr_tick, ld;
    logic [WIDE_W-1:0]  ld_val [NUM_TMR];
    logic [WIDE_W-1:0]  cnt_w  [NUM_TMR];
    t2src_e             src2;
    t2fn_e              fn2;
    logic               sel_rd;

    assign src2   = t2src_e'(r_q.seq[7:6]);
    assign fn2    = t2fn_e'(r_q.seq[5:4]);
    assign sel_rd = rd_en && (addr == A_SEL);

    // timer 2 clock source and function
    always_comb begin
        tmr_tick[1:0] = presc_tick[1:0];
        unique case (src2)
            SRC_OSC: tmr_tick[2] = (fn2 == FN_COUNT) ? osc_en : presc_tick[2];
            SRC_T1:  tmr_tick[2] = pace_tick[1];
            SRC_EOC: tmr_tick[2] = eoc_evt;
            default: tmr_tick[2] = eos_evt;
        endcase
    end

    // register window
    always_comb begin
        r_d = r_q;
        ld  = '0;
        for (int t = 0; t < NUM_TMR; t++) ld_val[t] = '0;

        if (wr_en) begin
            unique case (addr)
                A_SEL:   r_d.sel   = wdata[7:0];
                A_TMODE: r_d.tmode = wdata[5:0];
                A_CTRL:  r_d.gate  = wdata[14:12];
                A_SEQ:   r_d.seq   = wdata[7:0];
                A_DATA: begin
                    unique case (r_q.sel[1:0])
                        2'd0: begin
                            ld[0]     = 1'b1;
                            ld_val[0] = WIDE_W'(wdata);
                        end
                        2'd1: begin
                            ld[1]     = 1'b1;
                            ld_val[1] = WIDE_W'(wdata);
                        end
                        2'd2: r_d.stage2 = {r_q.stage2[WIDE_W-1:NARROW_W], wdata};
                        default: r_d.stage2 = {wdata[HI_W-1:0], r_q.stage2[NARROW_W-1:0]};
                    endcase
                    if (r_q.sel[1]) begin
                        ld[2]     = 1'b1;
                        ld_val[2] = r_d.stage2;
                    end
                end
                default: ;
            endcase
        end

        if (sel_rd) r_d.flag = 1'b0;
        if (term_tick[2]) r_d.flag = 1'b1;

        if (term_tick[2] && fn2 == FN_WDOG) r_d.bark = 1'b1;
        if (ld[2]) r_d.bark = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // read mux
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_SEL:    rdata = {8'h00, r_q.sel};
            A_TMODE:  rdata = {10'h000, r_q.tmode};
            A_CTRL:   rdata = {1'b0, r_q.gate, 12'h000};
            A_SEQ:    rdata = {8'h00, r_q.seq};
            A_STATUS: rdata = {3'b000, r_q.flag, 12'h000};
            A_DATA: begin
                unique case (r_q.sel[1:0])
                    2'd0:    rdata = cnt_w[0][NARROW_W-1:0];
                    2'd1:    rdata = cnt_w[1][NARROW_W-1:0];
                    2'd2:    rdata = cnt_w[2][NARROW_W-1:0];
                    default: rdata = NARROW_W'(cnt_w[2][WIDE_W-1:NARROW_W]);
                endcase
            end
            default: rdata = '0;
        endcase
    end

    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        localparam int P = (t == 0) ? PRESC0 : ((t == 1) ? PRESC1 : PRESC2);
        localparam int W = (t == 2) ? WIDE_W : NARROW_W;

        ttu_prescaler #(.DIV(P)) u_presc (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (osc_en),
            .tick_o (presc_tick[t])
        );

        ttu_counter #(.W(W)) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick_i     (tmr_tick[t]),
            .gate_i     (r_q.gate[t]),
            .mode_i     (tmode_e'(r_q.tmode[2*t +: 2])),
            .load_i     (ld[t]),
            .load_val_i (ld_val[t][W-1:0]),
            .trig_i     (hw_trig[t]),
            .cnt_o      (cnt_w[t][W-1:0]),
            .pulse_o    (pace_tick[t]),
            .term_o     (term_tick[t])
        );

        if (W < WIDE_W) begin : g_pad
            assign cnt_w[t][WIDE_W-1:W] = '0;
        end
    end

    assign irq       = r_q.flag && r_q.seq[2];
    assign wdog_bark = r_q.bark;
    assign dout      = r_q.sel[7:4];

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_rd && !term_tick[2]) |=> !irq);

    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term_tick[2] |=> (rdata[12] || addr != A_STATUS || r_q.flag));

    // R12
    dout_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_SEL) |=> (dout == $past(wdata[7:4])));

    // R11
    bark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_DATA && r_q.sel[1]) |=> !wdog_bark);

endmodule

// File: tb/tri_timer_unit_bench.sv
module tri_timer_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        eoc_evt = 1'b0;
    logic        eos_evt = 1'b0;
    logic [2:0]  hw_trig = '0;
    logic [2:0]  pace_tick, term_tick;
    logic        irq, wdog_bark;
    logic [3:0]  dout;

    int checks = 0;
    int errors = 0;

    localparam logic [2:0] SEL = 3'd0, DATA = 3'd1, TMODE = 3'd2,
                           CTRL = 3'd3, SEQ = 3'd4, STATUS = 3'd5;

    tri_timer_unit u_tri_timer_unit (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .eoc_evt(eoc_evt),
        .eos_evt(eos_evt), .hw_trig(hw_trig), .pace_tick(pace_tick),
        .term_tick(term_tick), .irq(irq), .wdog_bark(wdog_bark), .dout(dout)
    );

    always #4 clk = ~clk;

    function automatic int exp_period(int presc, int n);
        return presc * ((n < 2) ? 2 : n);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output int v);
        addr = a; rd_en = 1'b1;
        #1 v = int'(rdata);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic sig(int which);
        case (which)
            0: return pace_tick[0];
            1: return pace_tick[1];
            2: return irq;
            default: return term_tick[0];
        endcase
    endfunction

    task automatic wait_sig(int which, int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (sig(which)) begin n = i; break; end
        end
    endtask

    task automatic count_sig(int which, int cycles, output int c);
        c = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (sig(which)) c++;
        end
    endtask

    task automatic pulse_eoc();
        eoc_evt = 1'b1; @(negedge clk); eoc_evt = 1'b0; @(negedge clk);
    endtask

    task automatic pulse_eos();
        eos_evt = 1'b1; @(negedge clk); eos_evt = 1'b0; @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int v, n, c;
        void'($urandom(32'h5eed_0d17));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 pace_tick", int'(pace_tick), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 wdog_bark", int'(wdog_bark), 0);
        chk("R1 dout", int'(dout), 0);
        rd(TMODE, v);  chk("R1 mode reg", v, 0);
        rd(CTRL, v);   chk("R1 ctrl reg", v, 0);
        rd(SEQ, v);    chk("R1 seq reg", v, 0);
        rd(STATUS, v); chk("R1 status", v, 0);
        for (int t = 0; t < 4; t++) begin
            wr(SEL, 16'(t));
            rd(DATA, v); chk("R1 count", v, 0);
        end

        // R12 digital outputs follow select bits 7:4
        for (int i = 0; i < 5; i++) begin
            logic [3:0] lv = 4'($urandom);
            wr(SEL, {8'h00, lv, 4'h0});
            chk("R12 dout", int'(dout), int'(lv));
        end

        // R4 divisor clamp
        wr(SEL, 16'h0000);
        wr(DATA, 16'd0); rd(DATA, v); chk("R4 clamp 0", v, 2);
        wr(DATA, 16'd1); rd(DATA, v); chk("R4 clamp 1", v, 2);
        wr(DATA, 16'hFFFF); rd(DATA, v); chk("R4 max", v, 16'hFFFF);

        // R2 timer 0 rate generator, random divisors
        wr(TMODE, 16'h0001);
        wr(CTRL, 16'h1000);
        for (int i = 0; i < 4; i++) begin
            int nd = 2 + int'($urandom % 29);
            wr(SEL, 16'h0000);
            wr(DATA, 16'(nd));
            wait_sig(0, 10 * nd + 20, n);
            wait_sig(0, 10 * nd + 20, n);
            chk("R2 conv period", n, exp_period(10, nd));
        end

        // R5 gate clear holds count
        wr(CTRL, 16'h0000);
        rd(DATA, v);
        count_sig(0, 300, c);
        chk("R5 no pulse gated", c, 0);
        rd(DATA, n);
        chk("R5 count held", n, v);

        // R6 software strobe
        wr(TMODE, 16'h0002);
        wr(CTRL, 16'h1000);
        wr(DATA, 16'd3);
        count_sig(0, 60, c);  chk("R6 one pulse", c, 1);
        count_sig(0, 100, c); chk("R6 no repeat", c, 0);
        rd(DATA, v); chk("R6 rests at 0", v, 0);

        // R7 hardware strobe
        wr(TMODE, 16'h0003);
        wr(DATA, 16'd4);
        count_sig(0, 100, c); chk("R7 waits for trigger", c, 0);
        rd(DATA, v); chk("R7 count idle", v, 4);
        hw_trig[0] = 1'b1; @(negedge clk); hw_trig[0] = 1'b0;
        count_sig(0, 60, c);  chk("R7 one pulse after trigger", c, 1);

        // R13 mode 0: terminal event, no pace pulse
        wr(TMODE, 16'h0000);
        wr(DATA, 16'd3);
        count_sig(3, 60, c);  chk("R13 one term pulse", c, 1);
        wr(DATA, 16'd3);
        count_sig(0, 60, c);  chk("R13 no pace pulse", c, 0);
        rd(DATA, v); chk("R13 rests at 0", v, 0);
        wr(CTRL, 16'h0000);

        // R3 timer 1 scan pacing
        wr(TMODE, 16'h0004);
        wr(CTRL, 16'h2000);
        wr(SEL, 16'h0001);
        wr(DATA, 16'd2);
        wait_sig(1, 2100, n);
        wait_sig(1, 2100, n);
        chk("R3 scan period", n, exp_period(1000, 2));
        wr(CTRL, 16'h0000);

        // R8 timer 2 halves
        wr(TMODE, 16'h0000);
        wr(SEL, 16'h0002); wr(DATA, 16'h1234);
        wr(SEL, 16'h0003); wr(DATA, 16'h0056);
        rd(DATA, v); chk("R8 upper half", v, 16'h0056);
        wr(SEL, 16'h0002);
        rd(DATA, v); chk("R8 lower half", v, 16'h1234);

        // R9 terminal count, irq enabled
        wr(SEQ, 16'h0004);
        wr(DATA, 16'd2);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        wr(CTRL, 16'h4000);
        wait_sig(2, 2100, n);
        chk("R9 irq raised", int'(n > 0), 1);
        rd(STATUS, v); chk("R9 status flag", v, 16'h1000);
        rd(SEL, v);
        chk("R9 irq cleared", int'(irq), 0);
        rd(STATUS, v); chk("R9 status cleared", v, 0);

        // R9 irq disabled still sets flag
        wr(SEQ, 16'h0000);
        wr(DATA, 16'h0000);
        count_sig(2, 2100, c); chk("R9 irq masked", c, 0);
        rd(STATUS, v); chk("R9 flag while masked", v, 16'h1000);
        rd(SEL, v);

        // R10 end-of-conversion source
        wr(SEQ, 16'h0080);
        wr(SEL, 16'h0002); wr(DATA, 16'd3);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        pulse_eoc(); pulse_eoc();
        rd(STATUS, v); chk("R10 eoc two events", v, 0);
        pulse_eoc(); @(negedge clk);
        rd(STATUS, v); chk("R10 eoc third event", v, 16'h1000);
        rd(SEL, v);

        // R10 end-of-scan source, eoc ignored
        wr(SEQ, 16'h00C0);
        wr(SEL, 16'h0002); wr(DATA, 16'd2);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        pulse_eoc(); pulse_eos();
        rd(STATUS, v); chk("R10 eos one event", v, 0);
        pulse_eos(); @(negedge clk);
        rd(STATUS, v); chk("R10 eos second event", v, 16'h1000);
        rd(SEL, v);

        // R10 timer 1 output as source
        wr(SEQ, 16'h0040);
        wr(TMODE, 16'h0004);
        wr(CTRL, 16'h6000);
        wr(SEL, 16'h0001); wr(DATA, 16'd2);
        wr(SEL, 16'h0002); wr(DATA, 16'd2);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        repeat (2500) @(negedge clk);
        rd(STATUS, v); chk("R10 t1 source early", v, 0);
        repeat (1600) @(negedge clk);
        rd(STATUS, v); chk("R10 t1 source expired", v, 16'h1000);
        rd(SEL, v);
        wr(CTRL, 16'h4000);
        wr(TMODE, 16'h0000);

        // R11 counter function takes raw oscillator
        wr(SEQ, 16'h0010);
        wr(SEL, 16'h0002); wr(DATA, 16'd5);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        repeat (12) @(negedge clk);
        rd(STATUS, v); chk("R11 counter unprescaled", v, 16'h1000);
        chk("R11 no bark as counter", int'(wdog_bark), 0);
        rd(SEL, v);

        // R11 watchdog
        wr(SEQ, 16'h00A0);
        wr(SEL, 16'h0002); wr(DATA, 16'd2);
        wr(SEL, 16'h0003); wr(DATA, 16'h0000);
        chk("R11 bark idle", int'(wdog_bark), 0);
        pulse_eoc(); pulse_eoc(); @(negedge clk);
        chk("R11 bark set", int'(wdog_bark), 1);
        repeat (20) @(negedge clk);
        chk("R11 bark sticky", int'(wdog_bark), 1);
        wr(DATA, 16'h0000);
        chk("R11 bark cleared by load", int'(wdog_bark), 0);

        finish_run();
    end

endmodule